// File: doc/BRIEF.md
# Byte-Lane Hamming Protected Memory

A synchronous memory of `LANES` byte lanes (two by default, a 16-bit word) in which every byte lane keeps its own 4-bit Hamming check field next to its 8 data bits. A write encodes each enabled byte on its own and stores a 12-bit codeword for that lane. A read decodes each lane separately, so one flipped bit in each byte is repaired before the byte leaves the block. Two bits per word can therefore be repaired in one access. The lanes share no check bits, so a byte-masked write changes only its own lane and needs no read-modify-write.

Requests enter through a valid/ready port. A request moves when `req_valid` and `req_ready` are both high at a rising clock edge. Only reads produce a response. The response register holds one entry. While `rsp_valid` is high and `rsp_ready` is low, the response stays frozen and `req_ready` is low. A held response is therefore never overwritten, and no write passes a read that is still stalled. A test port XORs a 12-bit mask into the stored codeword of the selected lanes at one address. The depth is a parameter: 131072 words gives the full-size array, and smaller values give short simulations.

Top module: `ecc_byte_mem`

## Requirements
- R1: A write stores each enabled byte as a 12-bit codeword. Codeword bit i is position i+1. Check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in ascending order. The check bit at position 2^b is the even parity of the data positions whose index has bit b set.
- R2: A lane whose `req_be` bit is low during a write keeps both its data bits and its check bits unchanged.
- R3: A read returns the bytes of the enabled lanes. A lane that is not enabled returns 0x00, and its `rsp_fix` bit is 0, even when its stored codeword is damaged.
- R4: When the syndrome (the XOR of the positions of all set codeword bits) names a data position, the read flips that bit back and raises the lane's `rsp_fix` bit together with `rsp_valid`.
- R5: Both lanes of one word are repaired independently in the same read, and each raises its own `rsp_fix` bit.
- R6: A syndrome of 13, 14 or 15 leaves the data bits as stored and still raises `rsp_fix`.
- R7: A syndrome of 1, 2, 4 or 8 names a check bit. The read returns the stored data bits unchanged and raises `rsp_fix`.
- R8: A repaired value is never written back. Reading the same damaged word again raises `rsp_fix` again.
- R9: `rsp_valid` rises at the clock edge after a read is accepted. An accepted write produces no response.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` and `rsp_fix` hold their values and `req_ready` is low.
- R11: When `inj_en` is high, the block XORs `inj_mask` into the codeword at `inj_addr` of every lane selected in `inj_lanes`, and `req_ready` is low in that cycle.
- R12: After reset, `rsp_valid` is 0, and `req_ready` is 1 while `inj_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address, AW = clog2(DEPTH) |
| req_be | input | LANES | Lane enables for write and read |
| req_wdata | input | 8*LANES | Write data, lane g in bits 8g+7:8g |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 8*LANES | Repaired read data; 0 in lanes that are not enabled |
| rsp_fix | output | LANES | Per-lane flag: non-zero syndrome |
| inj_en | input | 1 | Apply the error mask this cycle |
| inj_addr | input | AW | Address for the mask |
| inj_lanes | input | LANES | Lanes that receive the mask |
| inj_mask | input | 12 | Bits XORed into the codeword |

## Verification
The bench builds the block with DEPTH set to 64 and two lanes. With only 64 addresses, random reads, writes and injections keep landing on words that earlier traffic has written or damaged. Masked writes therefore meet damaged neighbours, and repeated injections pile up into multi-bit syndromes, including the values above 12. With the small depth the bench can also fill the whole array before the random phase, so no read ever sees uninitialised storage. Directed cases walk a single flip through all twelve codeword positions of one lane, damage both lanes at once, force syndromes 13 and 15, and hold a response under back-pressure.

// File: rtl/ecc_byte_pkg.sv
package ecc_byte_pkg;
  localparam int LANE_W = 8;
  localparam int CW_W   = 12;
  localparam int SYN_W  = 4;

  typedef logic [LANE_W-1:0] byte_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [SYN_W-1:0]  syn_t;

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // codeword position (1-based) that carries data bit k
  function automatic int data_pos(input int k);
    int cnt;
    int res;
    cnt = -1;
    res = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_pow2(p)) begin
        cnt = cnt + 1;
        if (cnt == k) res = p;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/ecc_lane_enc.sv
module ecc_lane_enc
  import ecc_byte_pkg::*;
(
  input  byte_t data_i,
  output cw_t   cw_o
);
  always_comb begin
    cw_o = '0;
    for (int k = 0; k < LANE_W; k++) cw_o[data_pos(k)-1] = data_i[k];
    for (int b = 0; b < SYN_W; b++) begin
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> b) & 1) == 1 && !is_pow2(p))
          cw_o[(1 << b) - 1] = cw_o[(1 << b) - 1] ^ cw_o[p-1];
      end
    end
  end
endmodule

// File: rtl/ecc_lane_dec.sv
module ecc_lane_dec
  import ecc_byte_pkg::*;
(
  input  cw_t   cw_i,
  output byte_t data_o,
  output logic  err_o
);
  syn_t  syn;
  cw_t   fixed;
  byte_t raw;

  always_comb begin
    syn = '0;
    for (int p = 1; p <= CW_W; p++)
      if (cw_i[p-1]) syn = syn ^ SYN_W'(p);
  end

  always_comb begin
    fixed = cw_i;
    if (syn != '0 && syn <= SYN_W'(CW_W))
      fixed[syn - 1'b1] = ~fixed[syn - 1'b1];
  end

  always_comb begin
    for (int k = 0; k < LANE_W; k++) begin
      data_o[k] = fixed[data_pos(k)-1];
      raw[k]    = cw_i[data_pos(k)-1];
    end
  end

  assign err_o = (syn != '0);

  // R4: returned data may differ from stored data only when the flag is up
  always_comb begin
    a_r4_change_needs_flag: assert (data_o == raw || err_o);
  end
endmodule

// File: rtl/ecc_lane_store.sv
module ecc_lane_store
  import ecc_byte_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  cw_t           wr_cw,
  input  logic          inj_en,
  input  logic [AW-1:0] inj_addr,
  input  cw_t           inj_mask,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output cw_t           rd_cw
);
  cw_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (inj_en)     mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    else if (wr_en) mem[wr_addr]  <= wr_cw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_cw <= '0;
    else if (rd_en) rd_cw <= mem[rd_addr];
  end

  // R11: the request side never writes in a cycle that carries an injection
  a_r11_inj_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |-> !wr_en);
endmodule

// File: rtl/ecc_byte_mem.sv
module ecc_byte_mem
  import ecc_byte_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int LANES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [LANES-1:0] req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic [LANES-1:0] rsp_fix,
  input  logic             inj_en,
  input  logic [AW-1:0]    inj_addr,
  input  logic [LANES-1:0] inj_lanes,
  input  logic [CW_W-1:0]  inj_mask
);
  logic             accept, rd_fire, wr_fire;
  logic [LANES-1:0] be_q;

  assign req_ready = (!rsp_valid || rsp_ready) && !inj_en;
  assign accept    = req_valid && req_ready;
  assign rd_fire   = accept && !req_write;
  assign wr_fire   = accept && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      be_q      <= '0;
    end else begin
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        be_q      <= req_be;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cw_t   enc_cw, rd_cw;
    byte_t dec_data;
    logic  dec_err;

    ecc_lane_enc u_enc (
      .data_i (req_wdata[g*LANE_W +: LANE_W]),
      .cw_o   (enc_cw)
    );

    ecc_lane_store #(.DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_fire && req_be[g]),
      .wr_addr  (req_addr),
      .wr_cw    (enc_cw),
      .inj_en   (inj_en && inj_lanes[g]),
      .inj_addr (inj_addr),
      .inj_mask (inj_mask),
      .rd_en    (rd_fire),
      .rd_addr  (req_addr),
      .rd_cw    (rd_cw)
    );

    ecc_lane_dec u_dec (
      .cw_i   (rd_cw),
      .data_o (dec_data),
      .err_o  (dec_err)
    );

    assign rsp_rdata[g*LANE_W +: LANE_W] = be_q[g] ? dec_data : '0;
    assign rsp_fix[g] = rsp_valid && be_q[g] && dec_err;
  end

  // R9: response appears one edge after an accepted read
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);
  // R9: an accepted write leaves no response behind
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !rsp_valid);
  // R10: a stalled response is frozen
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_fix)));
  // R3: flags only in lanes the read enabled
  a_r3_fix_in_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> ((rsp_fix & ~$past(req_be)) == '0));
endmodule

// File: tb/sim_ecc_byte_mem.sv
module sim_ecc_byte_mem;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic [1:0]  rsp_fix;
  logic        inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [1:0]  inj_lanes = '0;
  logic [11:0] inj_mask = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [11:0] mdl [DEPTH][2];

  always #5 clk = ~clk;

  ecc_byte_mem #(.DEPTH(DEPTH), .LANES(2)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_be,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_fix,
    .inj_en, .inj_addr, .inj_lanes, .inj_mask
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1 layout written out bit by bit
  function automatic logic [11:0] m_enc(input logic [7:0] d);
    logic [11:0] c;
    c = '0;
    c[2] = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
    c[8] = d[4]; c[9] = d[5]; c[10] = d[6]; c[11] = d[7];
    c[0] = c[2] ^ c[4] ^ c[6] ^ c[8] ^ c[10];
    c[1] = c[2] ^ c[5] ^ c[6] ^ c[9] ^ c[10];
    c[3] = c[4] ^ c[5] ^ c[6] ^ c[11];
    c[7] = c[8] ^ c[9] ^ c[10] ^ c[11];
    return c;
  endfunction

  function automatic logic [8:0] m_dec(input logic [11:0] c);
    logic [3:0] s;
    logic [11:0] f;
    s[0] = c[0] ^ c[2] ^ c[4] ^ c[6] ^ c[8] ^ c[10];
    s[1] = c[1] ^ c[2] ^ c[5] ^ c[6] ^ c[9] ^ c[10];
    s[2] = c[3] ^ c[4] ^ c[5] ^ c[6] ^ c[11];
    s[3] = c[7] ^ c[8] ^ c[9] ^ c[10] ^ c[11];
    f = c;
    if (s >= 4'd1 && s <= 4'd12) f[s - 4'd1] = ~f[s - 4'd1];
    return {(s != 4'd0), f[11], f[10], f[9], f[8], f[6], f[5], f[4], f[2]};
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
    @(posedge clk);
    #1;
    for (int g = 0; g < 2; g++) if (be[g]) mdl[a][g] = m_enc(d[g*8 +: 8]);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_inject(input logic [AW-1:0] a, input logic [1:0] ln, input logic [11:0] m);
    @(negedge clk);
    inj_en = 1; inj_addr = a; inj_lanes = ln; inj_mask = m;
    #1 chk("R11 req_ready low during injection", req_ready, 0);
    @(posedge clk);
    #1;
    for (int g = 0; g < 2; g++) if (ln[g]) mdl[a][g] = mdl[a][g] ^ m;
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic do_read(input string tag, input logic [AW-1:0] a, input logic [1:0] be);
    logic [15:0] ed;
    logic [1:0]  ef;
    logic [8:0]  r;
    ed = '0; ef = '0;
    for (int g = 0; g < 2; g++) begin
      r = m_dec(mdl[a][g]);
      if (be[g]) begin ed[g*8 +: 8] = r[7:0]; ef[g] = r[8]; end
    end
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be; rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R9 rsp_valid"}, rsp_valid, 1);
    chk({tag, " data"}, rsp_rdata, ed);
    chk({tag, " fix"}, rsp_fix, ef);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] held;
    logic [1:0] heldf;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R12 rsp_valid after reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 req_ready after reset", req_ready, 1);

    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), 2'b11, 16'($urandom));
    #1 chk("R9 no response after write", rsp_valid, 0);

    do_read("R1 plain read", 6'd5, 2'b11);
    do_write(6'd5, 2'b01, 16'hA53C);
    do_read("R2 upper lane kept", 6'd5, 2'b11);
    do_write(6'd5, 2'b10, 16'h7E81);
    do_read("R2 lower lane kept", 6'd5, 2'b11);

    do_inject(6'd7, 2'b10, 12'h010);
    do_read("R3 lower only, upper damaged", 6'd7, 2'b01);
    chk("R3 masked upper byte is zero", rsp_rdata[15:8], 0);
    do_read("R3 upper only", 6'd7, 2'b10);

    for (int p = 0; p < 12; p++) begin
      do_inject(6'd10, 2'b01, 12'(1 << p));
      do_read((p == 0 || p == 1 || p == 3 || p == 7) ? "R7 check bit flip" : "R4 data bit flip",
              6'd10, 2'b11);
      chk("R4 flag on single flip", rsp_fix[0], 1);
      do_inject(6'd10, 2'b01, 12'(1 << p));
    end

    do_inject(6'd11, 2'b01, 12'h020);
    do_inject(6'd11, 2'b10, 12'h400);
    do_read("R5 both lanes", 6'd11, 2'b11);
    chk("R5 both flags", rsp_fix, 2'b11);

    d = {m_dec(mdl[12][1])[7:0], m_dec(mdl[12][0])[7:0]};
    do_inject(6'd12, 2'b01, 12'h801);
    do_read("R6 syndrome 13", 6'd12, 2'b11);
    chk("R6 syndrome 13 data as stored", rsp_rdata, d ^ 16'h0080);
    do_inject(6'd12, 2'b01, 12'h801);
    do_inject(6'd12, 2'b10, 12'h804);
    do_read("R6 syndrome 15", 6'd12, 2'b11);
    chk("R6 syndrome 15 data as stored", rsp_rdata, d ^ 16'h8100);

    do_inject(6'd13, 2'b01, 12'h100);
    do_read("R8 first read", 6'd13, 2'b11);
    do_read("R8 second read", 6'd13, 2'b11);
    chk("R8 still flagged", rsp_fix[0], 1);

    // R10 back-pressure
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 6'd13; req_be = 2'b11; rsp_ready = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    held = rsp_rdata; heldf = rsp_fix;
    chk("R10 rsp_valid while stalled", rsp_valid, 1);
    chk("R10 req_ready low while stalled", req_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 data held", rsp_rdata, held);
      chk("R10 fix held", rsp_fix, heldf);
    end
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 released", rsp_valid, 0);

    for (int i = 0; i < 400; i++) begin
      int op;
      logic [AW-1:0] a;
      op = int'($urandom % 4);
      a = AW'($urandom);
      if (op == 0) do_write(a, 2'($urandom), 16'($urandom));
      else if (op == 1) do_inject(a, 2'($urandom), 12'(1 << ($urandom % 12)));
      else do_read("R4 random read", a, 2'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule